// File: doc/BRIEF.md
# Triggered Serial Frame Capture Buffer

This block takes a 64-bit serial status frame from a line receiver and keeps it for a slow host to collect whenever it is ready. It has two states: idle and busy. While idle, with the host enable high, any level change on the serial data line starts a capture and the block goes busy. While busy, one data bit is taken on each one-cycle bit strobe. The 64th strobe returns the block to idle and freezes the frame. The host sees a finished frame as a falling edge on the busy output.

To read the frame, the host drops the enable so that new captures are blocked. It then steps a host clock. The frame is held in eight 8-bit stages, and each stage drives one bit of an 8-bit slice port. Each rising edge of the host clock rotates every stage by one bit, which brings the next slice to the port. The first slice is on the port before any step, and seven more steps deliver the rest of the frame. An eighth step brings back the first slice.

The serial data, host enable and host clock inputs are asynchronous. Each one passes through a two-flop synchronizer before the block uses it. The bit strobe is a pulse already in the system clock domain. The serial line must rest low through reset so that leaving reset does not look like a transition.

Top module: `frame_capture_buf`

## Requirements
- R1: After synchronous reset, busy_o is 0 and slice_o is all zeros, and the counter is cleared.
- R2: While idle with host_en_i high, a transition of ser_data_i in either direction sets busy_o. busy_o goes high on the third rising clock edge after the input changes.
- R3: While host_en_i is low, transitions of ser_data_i start no capture. busy_o stays 0 and slice_o is unchanged.
- R4: While busy, each bit_strobe_i pulse shifts the synchronized data bit into the frame. busy_o stays high through the first 63 strobes and falls on the clock edge of the 64th. The counter is held at zero whenever the block is idle.
- R5: Data transitions while busy neither restart nor stop the capture, and they do not change the bit count.
- R6: Bits are numbered b0 to b63 in arrival order. After k host clock rising edges, counted modulo 8, slice_o bit i equals b(56 - 8*i + k). Eight steps restore the first slice.
- R7: Rising edges of host_step_i while busy do not rotate the stages.
- R8: While idle, bit_strobe_i is ignored. The captured frame stays unchanged until a new data transition starts the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ser_data_i | input | 1 | Serial data from the line receiver (asynchronous) |
| bit_strobe_i | input | 1 | One-cycle pulse that samples the current data bit |
| host_en_i | input | 1 | Host enable for new captures (asynchronous) |
| host_step_i | input | 1 | Host readout clock; rests high, and a rising edge steps the readout (asynchronous) |
| busy_o | output | 1 | High while a capture is in progress |
| slice_o | output | 8 | Current readout slice; bit i is the top bit of stage i |

## Verification
The embedded assertions check the following on every cycle:
- the counter stays at zero while idle and does not move between strobes;
- busy falls only on the 64th strobe;
- a capture can start only with the synchronized enable high;
- shifting and rotation are never requested together;
- the slice holds whenever neither is requested.

Only the bench scenarios can show the complete bit mapping from arrival order to slices and the wrap after eight steps. They also show that captures are blocked with the enable low, that host steps and extra strobes leave a held frame intact, and that transitions during a capture do not disturb it.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
    localparam int unsigned DEF_STAGE_W  = 8;
    localparam int unsigned DEF_N_STAGES = 8;
endpackage

// File: rtl/fcb_sync2.sv
module fcb_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign sync_o = st_q.sync;
endmodule

// File: rtl/fcb_ctrl.sv
module fcb_ctrl #(
    parameter int unsigned FRAME_BITS = 64
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic data_s_i,
    input  logic en_s_i,
    input  logic step_s_i,
    input  logic strobe_i,
    output logic busy_o,
    output logic shift_en_o,
    output logic rot_en_o
);
    localparam int unsigned CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             data_prev;
        logic             step_prev;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic data_edge;

    always_comb begin
        st_d           = st_q;
        st_d.data_prev = data_s_i;
        st_d.step_prev = step_s_i;
        data_edge      = data_s_i != st_q.data_prev;
        if (!st_q.busy) begin
            st_d.cnt = '0;
            if (en_s_i && data_edge) st_d.busy = 1'b1;
        end else if (strobe_i) begin
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign busy_o     = st_q.busy;
    assign shift_en_o = st_q.busy && strobe_i;
    assign rot_en_o   = !st_q.busy && step_s_i && !st_q.step_prev;

    // R4: counter is parked at zero whenever idle
    p_cnt_idle_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_q.busy |-> st_q.cnt == '0);
    // R5: without a strobe the count does not move while busy
    p_cnt_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.busy && !strobe_i) |=> $stable(st_q.cnt));
    // R4: busy ends only on the final strobe
    p_busy_fall_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(st_q.busy) |-> ($past(st_q.cnt) == LAST && $past(strobe_i)));
    // R3: a capture starts only with the enable present
    p_start_en_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(st_q.busy) |-> $past(en_s_i));
endmodule

// File: rtl/fcb_stage.sv
module fcb_stage #(
    parameter int unsigned W = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic shift_en_i,
    input  logic rot_en_i,
    input  logic ser_i,
    output logic ser_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } stage_state_t;

    stage_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en_i)    st_d.bits = {st_q.bits[W-2:0], ser_i};
        else if (rot_en_i) st_d.bits = {st_q.bits[W-2:0], st_q.bits[W-1]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign ser_o = st_q.bits[W-1];

    // R8: contents hold when neither shifting nor rotating
    p_stage_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!shift_en_i && !rot_en_i) |=> $stable(st_q.bits));
endmodule

// File: rtl/frame_capture_buf.sv
module frame_capture_buf #(
    parameter int unsigned STAGE_W  = fcb_pkg::DEF_STAGE_W,
    parameter int unsigned N_STAGES = fcb_pkg::DEF_N_STAGES
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                ser_data_i,
    input  logic                bit_strobe_i,
    input  logic                host_en_i,
    input  logic                host_step_i,
    output logic                busy_o,
    output logic [N_STAGES-1:0] slice_o
);
    localparam int unsigned FRAME_BITS = STAGE_W * N_STAGES;

    logic [2:0]          sync_q;
    logic                data_s, en_s, step_s;
    logic                shift_en, rot_en;
    logic [N_STAGES:0]   chain;

    fcb_sync2 #(.W(3)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i ({host_step_i, host_en_i, ser_data_i}),
        .sync_o  (sync_q)
    );

    assign data_s = sync_q[0];
    assign en_s   = sync_q[1];
    assign step_s = sync_q[2];

    fcb_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .data_s_i   (data_s),
        .en_s_i     (en_s),
        .step_s_i   (step_s),
        .strobe_i   (bit_strobe_i),
        .busy_o     (busy_o),
        .shift_en_o (shift_en),
        .rot_en_o   (rot_en)
    );

    assign chain[0] = data_s;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        fcb_stage #(.W(STAGE_W)) u_stage (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .shift_en_i (shift_en),
            .rot_en_i   (rot_en),
            .ser_i      (chain[g]),
            .ser_o      (chain[g+1])
        );
        assign slice_o[g] = chain[g+1];
    end

    // R7: shifting and rotation are never requested together
    p_excl_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({shift_en, rot_en}));
    // R8: idle with no step leaves the slice port steady
    p_slice_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!shift_en && !rot_en) |=> $stable(slice_o));
    // R1: reset state visible at the ports
    p_reset_r1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!busy_o && slice_o == '0));
endmodule

// File: tb/frame_capture_buf_tb_top.sv
module frame_capture_buf_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       ser_data, strobe, host_en, host_step;
    logic       busy;
    logic [7:0] slice;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    frame_capture_buf dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .ser_data_i   (ser_data),
        .bit_strobe_i (strobe),
        .host_en_i    (host_en),
        .host_step_i  (host_step),
        .busy_o       (busy),
        .slice_o      (slice)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, cycles=%0d expected<150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_slice(input logic [63:0] fr, input int k);
        logic [7:0] s;
        for (int i = 0; i < 8; i++) s[i] = fr[56 - 8*i + (k % 8)];
        return s;
    endfunction

    task automatic pulse_strobe();
        strobe = 1'b1;
        tick(1);
        strobe = 1'b0;
    endtask

    task automatic host_step_once();
        host_step = 1'b0;
        tick(4);
        host_step = 1'b1;
        tick(5);
    endtask

    // kick the line, then clock in 64 bits; optional noise inside the capture
    task automatic capture(input logic [63:0] fr, input bit noisy);
        ser_data = ~ser_data;
        tick(2);
        chk("R2 busy not yet", {63'd0, busy}, 64'd0);
        tick(1);
        chk("R2 busy after transition", {63'd0, busy}, 64'd1);
        for (int n = 0; n < 64; n++) begin
            ser_data = fr[n];
            tick(3);
            if (noisy && n % 9 == 4) begin
                host_step = 1'b0;
                tick(4);
                host_step = 1'b1;
                tick(4);
            end
            if (n == 63) chk("R4 busy before last strobe", {63'd0, busy}, 64'd1);
            pulse_strobe();
            if (noisy && n % 11 == 2) begin
                ser_data = ~ser_data;
                tick(4);
                chk("R5 busy through data toggle", {63'd0, busy}, 64'd1);
            end
        end
        chk("R4 busy falls on 64th strobe", {63'd0, busy}, 64'd0);
    endtask

    task automatic read_frame(input logic [63:0] fr, input string tag);
        host_en = 1'b0;
        tick(4);
        for (int k = 0; k <= 8; k++) begin
            chk({"R6 slice ", tag}, {56'd0, slice}, {56'd0, exp_slice(fr, k)});
            host_step_once();
        end
        // restore slice 1 position to slice 0 by completing a full turn
        for (int k = 0; k < 7; k++) host_step_once();
        chk({"R6 wrap ", tag}, {56'd0, slice}, {56'd0, exp_slice(fr, 0)});
        host_en = 1'b1;
        tick(4);
    endtask

    initial begin
        logic [63:0] fr;
        logic [7:0]  held;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; ser_data = 1'b0; strobe = 1'b0; host_en = 1'b0; host_step = 1'b1;
        tick(4);
        rst = 1'b0;
        chk("R1 busy after reset", {63'd0, busy}, 64'd0);
        chk("R1 slice after reset", {56'd0, slice}, 64'd0);
        tick(6);

        // R3: disabled transitions start nothing
        held = slice;
        for (int t = 0; t < 3; t++) begin
            ser_data = ~ser_data;
            tick(5);
            chk("R3 no capture when disabled", {63'd0, busy}, 64'd0);
        end
        chk("R3 slice unchanged", {56'd0, slice}, {56'd0, held});

        host_en = 1'b1;
        tick(4);

        // directed patterns then random frames
        for (int f = 0; f < 6; f++) begin
            case (f)
                0: fr = 64'hFFFF_FFFF_FFFF_FFFF;
                1: fr = 64'h0000_0000_0000_0001;
                2: fr = 64'h8000_0000_0000_0000;
                default: fr = {$urandom, $urandom};
            endcase
            capture(fr, f >= 3);
            // R8: idle strobes ignored, frame held
            for (int s = 0; s < 5; s++) begin
                tick(2);
                pulse_strobe();
            end
            tick(3);
            chk("R8 busy stays idle", {63'd0, busy}, 64'd0);
            chk("R8 held slice after strobes", {56'd0, slice}, {56'd0, exp_slice(fr, 0)});
            read_frame(fr, (f >= 3) ? "R7 random" : "directed");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule